// File: doc/BRIEF.md
# Capability Jump Target Checker

This block sits in the execute stage of a capability-aware processor. It handles the register-indirect jump-and-link instruction. It takes the target capability from a source register, a 12-bit signed immediate, the current program-counter capability, the interrupt-enable status and a flag that says whether compressed instructions are enabled. One cycle later it returns one of two results. The first is the capability to install as the new program counter, together with the capability to write into the link register. The second is an exception report made of a cause code and a register index.

The destination is deliberately not compared against any bounds. An out-of-range destination is left for the next instruction fetch to catch. Targets sealed as sentries are unsealed on the way into the program counter. Any other sealed target is refused. The link capability is a copy of the current program-counter capability. Its address is set to the return address, and it is sealed with a return-sentry type that records whether interrupts were enabled. All capabilities appear at the ports as explicit fields (tag, execute permission, object type, address). No compressed-format decoding is done here.

Object-type encoding used throughout:
- 0 means unsealed.
- 1 to 5 are sentry types.
- 4 is the return sentry with interrupts disabled, and 5 is the return sentry with interrupts enabled.
- 6 and 7 are ordinary (non-sentry) seals.

Cause codes:

| Code | Meaning |
|------|---------|
| 0 | none |
| 1 | tag violation |
| 2 | seal violation |
| 3 | execute-permission violation |
| 4 | misaligned destination |

Top module: `cjt_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero after that edge.
- R2: A request whose target tag is 0 reports `exc`=1 with cause 1, and `exc_idx` equal to `tgt_idx`.
- R3: A request whose target object type is 6 or 7 (sealed, not a sentry) reports cause 2, with `exc_idx` equal to `tgt_idx`.
- R4: A request whose target object type is a sentry (1 to 5) and whose immediate is nonzero reports cause 2, with `exc_idx` equal to `tgt_idx`.
- R5: A request whose target lacks execute permission (`tgt_exec`=0) reports cause 3, with `exc_idx` equal to `tgt_idx`.
- R6: The destination is the target address plus the sign-extended immediate. When bit 1 of that sum is 1 and `cmp_en` is 0, the request reports cause 4 with `exc_idx` 0. Bit 0 of the sum never causes a fault, and with `cmp_en`=1 bit 1 causes no fault either.
- R7: No bounds check is made. A fault-free request yields `npcc_addr` equal to the destination sum with bit 0 cleared, wrapping modulo 2^32, whatever the address value.
- R8: A fault-free request yields a new program-counter capability with object type 0, and with tag and execute permission taken from the target. Sentry targets are therefore unsealed.
- R9: A fault-free request sets `link_we`=1. The link capability has the tag and execute permission of the current program-counter capability, address `pcc_addr`+4, and object type 4 when `ie`=0 or 5 when `ie`=1.
- R10: A faulting request leaves all `npcc_*` and `link_*` outputs unchanged and keeps `link_we` at 0.
- R11: Results appear exactly one cycle after `req_valid`. In a cycle with no request, `rsp_valid`, `exc`, `cause`, `exc_idx` and `link_we` are 0 on the next cycle, and the capability outputs hold.
- R12: When several faults are present, only the highest is reported, in the order tag, seal, execute permission, alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Jump request present this cycle |
| tgt_tag | input | 1 | Target capability tag |
| tgt_otype | input | 3 | Target capability object type |
| tgt_exec | input | 1 | Target execute permission |
| tgt_addr | input | 32 | Target capability address |
| tgt_idx | input | 5 | Source register index of the target |
| imm | input | 12 | Signed jump offset |
| pcc_tag | input | 1 | Current program-counter capability tag |
| pcc_otype | input | 3 | Current program-counter capability object type |
| pcc_exec | input | 1 | Current program-counter execute permission |
| pcc_addr | input | 32 | Current program counter |
| ie | input | 1 | Interrupt-enable status |
| cmp_en | input | 1 | Compressed instructions enabled |
| rsp_valid | output | 1 | Result valid |
| exc | output | 1 | Exception raised |
| cause | output | 3 | Exception cause code |
| exc_idx | output | 5 | Register index reported with the exception |
| npcc_tag | output | 1 | New program-counter capability tag |
| npcc_otype | output | 3 | New program-counter capability object type |
| npcc_exec | output | 1 | New program-counter execute permission |
| npcc_addr | output | 32 | New program counter |
| link_we | output | 1 | Link register write enable |
| link_tag | output | 1 | Link capability tag |
| link_otype | output | 3 | Link capability object type |
| link_exec | output | 1 | Link execute permission |
| link_addr | output | 32 | Link return address |

## Verification
The assertions check four things on every cycle:
- an untagged target always yields the tag cause;
- an accepted jump always lands unsealed, on an address with bit 0 clear;
- the link sentry type and return address follow the interrupt-enable bit and the program counter of the request cycle;
- a fault freezes both capability outputs, and idle cycles report nothing.

Some properties only the bench's scenarios can show:
- the full priority among simultaneous faults;
- the split between bit 0 and bit 1 in the alignment rule under both compressed settings;
- wrap-around of destinations with no bounds check;
- the full set of sentry and non-sentry object types.

// File: rtl/cjt_pkg.sv
// Package: shared widths, the capability field struct, cause codes and
// object-type encodings for the capability jump target checker.
package cjt_pkg;
    parameter int XLEN    = 32;
    parameter int OTYPE_W = 3;
    parameter int IMM_W   = 12;
    parameter int RIDX_W  = 5;
    parameter int CAUSE_W = 3;
    parameter int JUMP_INSN_BYTES = 4;

    // Object types: 0 unsealed, SENTRY_LO..SENTRY_HI are sentries.
    localparam logic [OTYPE_W-1:0] OT_UNSEALED  = 3'd0;
    localparam logic [OTYPE_W-1:0] OT_SENTRY_LO = 3'd1;
    localparam logic [OTYPE_W-1:0] OT_SENTRY_HI = 3'd5;
    localparam logic [OTYPE_W-1:0] OT_RET_IDIS  = 3'd4;
    localparam logic [OTYPE_W-1:0] OT_RET_IEN   = 3'd5;

    typedef enum logic [CAUSE_W-1:0] {
        CZ_NONE  = 3'd0,
        CZ_TAG   = 3'd1,
        CZ_SEAL  = 3'd2,
        CZ_EXEC  = 3'd3,
        CZ_ALIGN = 3'd4
    } cause_e;

    typedef struct packed {
        logic               tag;
        logic               exec;
        logic [OTYPE_W-1:0] otype;
        logic [XLEN-1:0]    addr;
    } cap_t;
endpackage

// File: rtl/cjt_target_calc.sv
// Module: cjt_target_calc
// Forms the jump destination (target address plus sign-extended immediate)
// and the unsealed program-counter capability built from the target.
// Assumes: no bounds are applied; bit 0 of the destination is dropped.
module cjt_target_calc
    import cjt_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int IW = IMM_W
) (
    input  cap_t          tgt,
    input  logic [IW-1:0] imm,
    output logic [AW-1:0] dest_sum,
    output cap_t          new_pcc
);
    localparam int EXT_W = AW - IW;

    // Destination sum with sign extension of the immediate.
    always_comb begin
        dest_sum = tgt.addr + {{EXT_W{imm[IW-1]}}, imm};
    end

    // Installed capability: unsealed, bit 0 of the address cleared.
    always_comb begin
        new_pcc       = tgt;
        new_pcc.otype = OT_UNSEALED;
        new_pcc.addr  = {dest_sum[AW-1:1], 1'b0};
    end
endmodule

// File: rtl/cjt_fault_check.sv
// Module: cjt_fault_check
// Evaluates the four jump faults and reports the highest-priority one
// (tag, then seal, then execute permission, then alignment).
// Assumes: dest_bit1 is bit 1 of the destination sum.
module cjt_fault_check
    import cjt_pkg::*;
#(
    parameter int IW = IMM_W
) (
    input  cap_t          tgt,
    input  logic [IW-1:0] imm,
    input  logic          dest_bit1,
    input  logic          cmp_en,
    output logic          fault,
    output cause_e        fault_cause,
    output logic          fault_uses_reg
);
    logic is_sentry;
    logic f_tag, f_seal, f_exec, f_align;

    // Classify the target object type.
    always_comb begin
        is_sentry = (tgt.otype >= OT_SENTRY_LO) && (tgt.otype <= OT_SENTRY_HI);
    end

    // Individual fault conditions.
    always_comb begin
        f_tag   = !tgt.tag;
        f_seal  = ((tgt.otype != OT_UNSEALED) && !is_sentry) ||
                  (is_sentry && (imm != '0));
        f_exec  = !tgt.exec;
        f_align = dest_bit1 && !cmp_en;
    end

    // Priority selection of the reported cause.
    always_comb begin
        fault_cause = CZ_NONE;
        if (f_tag)        fault_cause = CZ_TAG;
        else if (f_seal)  fault_cause = CZ_SEAL;
        else if (f_exec)  fault_cause = CZ_EXEC;
        else if (f_align) fault_cause = CZ_ALIGN;
        fault          = (fault_cause != CZ_NONE);
        fault_uses_reg = fault && (fault_cause != CZ_ALIGN);
    end
endmodule

// File: rtl/cjt_link_gen.sv
// Module: cjt_link_gen
// Builds the link capability: current PCC, return address, sealed as a
// return sentry whose type follows the interrupt-enable bit.
module cjt_link_gen
    import cjt_pkg::*;
#(
    parameter int INSN_BYTES = JUMP_INSN_BYTES
) (
    input  cap_t pcc,
    input  logic ie,
    output cap_t link
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // Return-sentry link value.
    always_comb begin
        link       = pcc;
        link.addr  = pcc.addr + STEP;
        link.otype = ie ? OT_RET_IEN : OT_RET_IDIS;
    end
endmodule

// File: rtl/cjt_top.sv
// Module: cjt_top
// Register-indirect capability jump checker. One request per cycle is
// checked combinationally and the result is registered; a fault keeps the
// new-PCC and link outputs at their previous values.
// Assumes: synchronous active-low reset; no destination bounds check.
module cjt_top
    import cjt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                tgt_tag,
    input  logic [OTYPE_W-1:0]  tgt_otype,
    input  logic                tgt_exec,
    input  logic [XLEN-1:0]     tgt_addr,
    input  logic [RIDX_W-1:0]   tgt_idx,
    input  logic [IMM_W-1:0]    imm,
    input  logic                pcc_tag,
    input  logic [OTYPE_W-1:0]  pcc_otype,
    input  logic                pcc_exec,
    input  logic [XLEN-1:0]     pcc_addr,
    input  logic                ie,
    input  logic                cmp_en,
    output logic                rsp_valid,
    output logic                exc,
    output logic [CAUSE_W-1:0]  cause,
    output logic [RIDX_W-1:0]   exc_idx,
    output logic                npcc_tag,
    output logic [OTYPE_W-1:0]  npcc_otype,
    output logic                npcc_exec,
    output logic [XLEN-1:0]     npcc_addr,
    output logic                link_we,
    output logic                link_tag,
    output logic [OTYPE_W-1:0]  link_otype,
    output logic                link_exec,
    output logic [XLEN-1:0]     link_addr
);
    cap_t      tgt_c, pcc_c, cand_pcc, cand_link;
    cap_t      npcc_q, link_q;
    logic [XLEN-1:0] dest_sum;
    logic      fault, fault_uses_reg;
    cause_e    fault_cause;

    // Pack port fields into capability structs.
    always_comb begin
        tgt_c = '{tag: tgt_tag, exec: tgt_exec, otype: tgt_otype, addr: tgt_addr};
        pcc_c = '{tag: pcc_tag, exec: pcc_exec, otype: pcc_otype, addr: pcc_addr};
    end

    cjt_target_calc #(.AW(XLEN), .IW(IMM_W)) u_calc (
        .tgt      (tgt_c),
        .imm      (imm),
        .dest_sum (dest_sum),
        .new_pcc  (cand_pcc)
    );

    cjt_fault_check #(.IW(IMM_W)) u_fault (
        .tgt            (tgt_c),
        .imm            (imm),
        .dest_bit1      (dest_sum[1]),
        .cmp_en         (cmp_en),
        .fault          (fault),
        .fault_cause    (fault_cause),
        .fault_uses_reg (fault_uses_reg)
    );

    cjt_link_gen #(.INSN_BYTES(JUMP_INSN_BYTES)) u_link (
        .pcc  (pcc_c),
        .ie   (ie),
        .link (cand_link)
    );

    // Result register: report status every cycle, update capabilities on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            exc       <= 1'b0;
            cause     <= '0;
            exc_idx   <= '0;
            link_we   <= 1'b0;
            npcc_q    <= '0;
            link_q    <= '0;
        end else begin
            rsp_valid <= req_valid;
            exc       <= req_valid && fault;
            cause     <= req_valid ? fault_cause : CZ_NONE;
            exc_idx   <= (req_valid && fault_uses_reg) ? tgt_idx : '0;
            link_we   <= req_valid && !fault;
            if (req_valid && !fault) begin
                npcc_q <= cand_pcc;
                link_q <= cand_link;
            end
        end
    end

    // Unpack registered capabilities onto the ports.
    always_comb begin
        npcc_tag   = npcc_q.tag;
        npcc_exec  = npcc_q.exec;
        npcc_otype = npcc_q.otype;
        npcc_addr  = npcc_q.addr;
        link_tag   = link_q.tag;
        link_exec  = link_q.exec;
        link_otype = link_q.otype;
        link_addr  = link_q.addr;
    end
endmodule

// File: rtl/cjt_checker.sv
// Module: cjt_checker
// Concurrent properties on the ports of cjt_top, attached by bind below.
module cjt_checker
    import cjt_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                tgt_tag,
    input logic [XLEN-1:0]     pcc_addr,
    input logic                ie,
    input logic                rsp_valid,
    input logic                exc,
    input logic [CAUSE_W-1:0]  cause,
    input logic [RIDX_W-1:0]   exc_idx,
    input logic                npcc_tag,
    input logic [OTYPE_W-1:0]  npcc_otype,
    input logic                npcc_exec,
    input logic [XLEN-1:0]     npcc_addr,
    input logic                link_we,
    input logic                link_tag,
    input logic [OTYPE_W-1:0]  link_otype,
    input logic                link_exec,
    input logic [XLEN-1:0]     link_addr
);
    assert_untagged_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tgt_tag) |=> (exc && cause == 3'd1));

    assert_lands_unsealed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !exc) |-> (npcc_otype == 3'd0));

    assert_bit0_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !exc) |-> (npcc_addr[0] == 1'b0));

    assert_link_sentry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_otype == ($past(ie) ? 3'd5 : 3'd4)
                     && link_addr == $past(pcc_addr) + 32'd4));

    assert_fault_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (!link_we && $stable(npcc_addr) && $stable(npcc_otype) &&
                 $stable(npcc_tag) && $stable(npcc_exec) && $stable(link_addr) &&
                 $stable(link_otype) && $stable(link_tag) && $stable(link_exec)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!exc && !link_we && cause == '0 && exc_idx == '0));

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
endmodule

bind cjt_top cjt_checker u_cjt_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tgt_tag(tgt_tag),
    .pcc_addr(pcc_addr), .ie(ie), .rsp_valid(rsp_valid), .exc(exc),
    .cause(cause), .exc_idx(exc_idx), .npcc_tag(npcc_tag),
    .npcc_otype(npcc_otype), .npcc_exec(npcc_exec), .npcc_addr(npcc_addr),
    .link_we(link_we), .link_tag(link_tag), .link_otype(link_otype),
    .link_exec(link_exec), .link_addr(link_addr)
);

// File: tb/cjt_top_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated at each rising edge, compared
// with every output at each falling edge.
module cjt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        tgt_tag, tgt_exec;
    logic [2:0]  tgt_otype;
    logic [31:0] tgt_addr;
    logic [4:0]  tgt_idx;
    logic [11:0] imm;
    logic        pcc_tag, pcc_exec;
    logic [2:0]  pcc_otype;
    logic [31:0] pcc_addr;
    logic        ie, cmp_en;
    logic        rsp_valid, exc, link_we;
    logic [2:0]  cause;
    logic [4:0]  exc_idx;
    logic        npcc_tag, npcc_exec, link_tag, link_exec;
    logic [2:0]  npcc_otype, link_otype;
    logic [31:0] npcc_addr, link_addr;

    int vectors = 0;
    int fails   = 0;
    bit started = 0;

    always #5 clk = ~clk;

    cjt_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .tgt_tag(tgt_tag), .tgt_otype(tgt_otype), .tgt_exec(tgt_exec),
        .tgt_addr(tgt_addr), .tgt_idx(tgt_idx), .imm(imm),
        .pcc_tag(pcc_tag), .pcc_otype(pcc_otype), .pcc_exec(pcc_exec),
        .pcc_addr(pcc_addr), .ie(ie), .cmp_en(cmp_en),
        .rsp_valid(rsp_valid), .exc(exc), .cause(cause), .exc_idx(exc_idx),
        .npcc_tag(npcc_tag), .npcc_otype(npcc_otype), .npcc_exec(npcc_exec),
        .npcc_addr(npcc_addr), .link_we(link_we), .link_tag(link_tag),
        .link_otype(link_otype), .link_exec(link_exec), .link_addr(link_addr)
    );

    // Reference model state.
    int          e_rsp, e_exc, e_cause, e_idx, e_lwe;
    int          e_ntag, e_nexec, e_notype, e_ltag, e_lexec, e_lotype;
    logic [31:0] e_naddr, e_laddr;
    string       lbl_st, lbl_np, lbl_lk;

    // Model: evaluate the rules for the request seen at this edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            e_rsp = 0; e_exc = 0; e_cause = 0; e_idx = 0; e_lwe = 0;
            e_ntag = 0; e_nexec = 0; e_notype = 0; e_naddr = 0;
            e_ltag = 0; e_lexec = 0; e_lotype = 0; e_laddr = 0;
            lbl_st = "R1"; lbl_np = "R1"; lbl_lk = "R1";
        end else if (req_valid) begin
            logic [31:0] dest;
            bit sentry, ft, fs, fx, fa;
            int nf;
            dest   = tgt_addr + 32'($signed(imm));
            sentry = (tgt_otype >= 1) && (tgt_otype <= 5);
            ft = !tgt_tag;
            fs = (tgt_otype != 0 && !sentry) || (sentry && imm != 0);
            fx = !tgt_exec;
            fa = dest[1] && !cmp_en;
            nf = int'(ft) + int'(fs) + int'(fx) + int'(fa);
            e_rsp = 1;
            if (ft)      begin e_cause = 1; lbl_st = "R2"; end
            else if (fs) begin e_cause = 2; lbl_st = (sentry ? "R4" : "R3"); end
            else if (fx) begin e_cause = 3; lbl_st = "R5"; end
            else if (fa) begin e_cause = 4; lbl_st = "R6"; end
            else         begin e_cause = 0; lbl_st = "R6"; end
            if (nf > 1) lbl_st = "R12";
            e_exc = (nf > 0);
            e_idx = (e_cause >= 1 && e_cause <= 3) ? int'(tgt_idx) : 0;
            e_lwe = (nf == 0);
            if (nf == 0) begin
                e_ntag = tgt_tag; e_nexec = tgt_exec; e_notype = 0;
                e_naddr = dest & 32'hFFFF_FFFE;
                e_ltag = pcc_tag; e_lexec = pcc_exec;
                e_lotype = ie ? 5 : 4; e_laddr = pcc_addr + 32'd4;
                lbl_np = "R8"; lbl_lk = "R9";
            end else begin
                lbl_np = "R10"; lbl_lk = "R10";
            end
        end else begin
            e_rsp = 0; e_exc = 0; e_cause = 0; e_idx = 0; e_lwe = 0;
            lbl_st = "R11"; lbl_np = "R11"; lbl_lk = "R11";
        end
    end

    task automatic chk(string req, string fld, logic [31:0] act, logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, fld, act, exp, $time);
        end
    endtask

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        if (started) begin
            vectors++;
            chk(lbl_st, "rsp_valid", 32'(rsp_valid), 32'(e_rsp));
            chk(lbl_st, "exc",       32'(exc),       32'(e_exc));
            chk(lbl_st, "cause",     32'(cause),     32'(e_cause));
            chk(lbl_st, "exc_idx",   32'(exc_idx),   32'(e_idx));
            chk(lbl_lk, "link_we",   32'(link_we),   32'(e_lwe));
            chk(lbl_np, "npcc_tag",  32'(npcc_tag),  32'(e_ntag));
            chk(lbl_np, "npcc_exec", 32'(npcc_exec), 32'(e_nexec));
            chk(lbl_np, "npcc_otype",32'(npcc_otype),32'(e_notype));
            chk((lbl_np == "R8") ? "R7" : lbl_np, "npcc_addr", npcc_addr, e_naddr);
            chk(lbl_lk, "link_tag",  32'(link_tag),  32'(e_ltag));
            chk(lbl_lk, "link_exec", 32'(link_exec), 32'(e_lexec));
            chk(lbl_lk, "link_otype",32'(link_otype),32'(e_lotype));
            chk(lbl_lk, "link_addr", link_addr,      e_laddr);
        end
    end

    task automatic jump(bit tt, logic [2:0] ot, bit tx, logic [31:0] ta, logic [4:0] ti,
                        logic [11:0] im, logic [31:0] pa, bit ien, bit cen);
        @(negedge clk);
        req_valid = 1; tgt_tag = tt; tgt_otype = ot; tgt_exec = tx;
        tgt_addr = ta; tgt_idx = ti; imm = im;
        pcc_tag = 1; pcc_otype = 0; pcc_exec = 1; pcc_addr = pa;
        ie = ien; cmp_en = cen;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; tgt_tag = 0; tgt_otype = 0; tgt_exec = 0;
        tgt_addr = 0; tgt_idx = 0; imm = 0; pcc_tag = 0; pcc_otype = 0;
        pcc_exec = 0; pcc_addr = 0; ie = 0; cmp_en = 0;
        repeat (3) @(negedge clk);               // R1 reset state compared
        rst_n = 1;
        jump(1, 0, 1, 32'h0000_1000, 5'd3, 12'h010, 32'h200, 0, 0); // plain ok, R9 ie=0
        jump(1, 0, 1, 32'h0000_2000, 5'd4, 12'h800, 32'h300, 1, 0); // negative imm, ie=1
        jump(0, 0, 1, 32'h0000_1000, 5'd7, 12'h000, 32'h400, 0, 0); // R2 untagged
        idle();                                                     // R11
        jump(1, 3'd6, 1, 32'h0000_1000, 5'd8, 12'h000, 32'h400, 0, 0); // R3
        jump(1, 3'd7, 1, 32'h0000_1000, 5'd9, 12'h000, 32'h400, 0, 0); // R3
        jump(1, 3'd1, 1, 32'h0000_1000, 5'd10, 12'h004, 32'h400, 0, 0); // R4
        jump(1, 3'd5, 1, 32'h0000_3000, 5'd11, 12'h000, 32'h500, 1, 0); // R8 sentry unsealed
        jump(1, 0, 0, 32'h0000_1000, 5'd12, 12'h000, 32'h400, 0, 0); // R5
        jump(1, 0, 1, 32'h0000_1002, 5'd13, 12'h000, 32'h400, 0, 0); // R6 misaligned
        jump(1, 0, 1, 32'h0000_1002, 5'd13, 12'h000, 32'h600, 0, 1); // R6 compressed ok
        jump(1, 0, 1, 32'h0000_1001, 5'd13, 12'h000, 32'h700, 0, 0); // R6 bit 0 ignored
        jump(1, 0, 1, 32'hFFFF_FFFC, 5'd14, 12'h008, 32'h800, 1, 0); // R7 wrap
        jump(0, 3'd6, 0, 32'h0000_1002, 5'd15, 12'h000, 32'h900, 0, 0); // R12 all faults
        jump(1, 3'd6, 0, 32'h0000_1002, 5'd16, 12'h000, 32'h900, 0, 0); // R12 seal first
        jump(1, 0, 0, 32'h0000_1002, 5'd17, 12'h000, 32'h900, 0, 0);   // R12 exec first
        idle(); idle();
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 4) == 0) idle();
            else jump(1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
                      1'($urandom_range(0, 7) != 0), $urandom, 5'($urandom),
                      ($urandom_range(0, 1) == 0) ? 12'h000 : 12'($urandom),
                      $urandom, 1'($urandom), 1'($urandom));
        end
        idle();
        rst_n = 0; idle();                       // R1 reset after activity
        rst_n = 1; idle(); idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule